// File: doc/BRIEF.md
# Programmable Bit-Rate and Timer Pulse Generator

This block turns one 8-bit rate value into two timing sources for a low-speed modem port. The first source is a 16x oversampling enable for the serial shifters, with a one-per-bit tick taken from it. The second is a slow, asymmetric square wave that software polls as a time base. Both sources are counted from a 250 kHz reference enable, which a prescaler derives from the system clock.

The rate value R sets the bit rate to 250000 / (16 × R) and the timer period to 0.4 × R ms. That period is 100 × R reference ticks. The timer output is high for 40 % of each period and low for the other 60 %. A rate of zero is a special case. It keeps the bit-rate divisor already in use and freezes the timer output at its present level. Out of reset the divisor is 52, which gives roughly 300 baud, and the timer is frozen low.

Top module: `rate_timer_gen`

## Requirements
- R1: While reset is held and just after it, all three outputs are low. Out of reset the 16x tick repeats every 52 × SYS_DIV clocks, and the timer output stays low until a nonzero rate is loaded.
- R2: With an active divisor R, the 16x tick is a one-clock pulse that repeats every R × SYS_DIV clocks. The first pulse comes R × SYS_DIV clocks after the clock edge that samples the load.
- R3: The bit tick pulses together with every 16th 16x tick. The first bit tick comes 16 × R × SYS_DIV clocks after the load edge.
- R4: A nonzero load drives the timer output low at the load edge. The output rises 60 × R × SYS_DIV clocks later, then stays high for 40 × R × SYS_DIV clocks and low for 60 × R × SYS_DIV clocks, and repeats.
- R5: Every load restarts the prescaler, the 16x divider, the bit counter and the timer phase counter. A second load made before the first one's period completes leaves no trace of the first.
- R6: A load of zero keeps the previous bit-rate divisor, with its chain restarted. The timer output holds its level with no edges until a nonzero value is loaded.
- R7: The timing of R2 to R4 holds at the extreme rates 1 and 255.
- R8: The rate input is ignored in any cycle where the load strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_in | input | RW | Rate value R, sampled when rate_ld is high |
| rate_ld | input | 1 | Load strobe for rate_in |
| tick16 | output | 1 | 16x bit-rate enable, one clock wide |
| baud_tick | output | 1 | One-per-bit enable, one clock wide |
| tmr_pulse | output | 1 | Timer pulse level (40 % high, 60 % low) |

## Verification
The checker assumes that the rate input can change freely but matters only when the load strobe is high. It also assumes SYS_DIV is at least 2, so two 16x ticks can never fall on adjacent clocks. The bench keeps to both assumptions by running with SYS_DIV of 2 and by scrambling rate_in while the strobe is low. It issues each load as a single-cycle strobe. It sets the scored window after every load so that no expected event falls on the load cycle itself. Events that leftover state from an earlier rate produces before that load are not scored.

// File: rtl/rate_timer_gen.sv
module rate_timer_gen #(
  parameter int SYS_DIV  = 40,
  parameter int RW       = 8,
  parameter int DEF_RATE = 52,
  parameter int HI_MULT  = 40,
  parameter int LO_MULT  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rate_in,
  input  logic          rate_ld,
  output logic          tick16,
  output logic          baud_tick,
  output logic          tmr_pulse
);
  localparam int PSW  = $clog2(SYS_DIV + 1);
  localparam int MAXM = (HI_MULT > LO_MULT) ? HI_MULT : LO_MULT;
  localparam int TW   = $clog2((2**RW - 1) * MAXM + 1);

  logic [PSW-1:0] pre_cnt;
  logic [RW-1:0]  div_r, div_cnt, tmr_r;
  logic [3:0]     sub_cnt;
  logic [TW-1:0]  tmr_cnt;

  wire ref_en   = (pre_cnt == PSW'(SYS_DIV - 1));
  wire div_wrap = ref_en && (div_cnt == div_r - RW'(1));
  wire tmr_on   = |tmr_r;
  wire [TW-1:0] hi_len = TW'(tmr_r) * TW'(HI_MULT);
  wire [TW-1:0] lo_len = TW'(tmr_r) * TW'(LO_MULT);
  wire [TW-1:0] phase_end = (tmr_pulse ? hi_len : lo_len) - TW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      div_r     <= RW'(DEF_RATE);
      div_cnt   <= '0;
      sub_cnt   <= '0;
      tick16    <= 1'b0;
      baud_tick <= 1'b0;
      tmr_r     <= '0;
      tmr_cnt   <= '0;
      tmr_pulse <= 1'b0;
    end else if (rate_ld) begin
      pre_cnt   <= '0;
      div_cnt   <= '0;
      sub_cnt   <= '0;
      tick16    <= 1'b0;
      baud_tick <= 1'b0;
      tmr_cnt   <= '0;
      tmr_r     <= rate_in;
      if (|rate_in) begin
        div_r     <= rate_in;
        tmr_pulse <= 1'b0;
      end
    end else begin
      pre_cnt   <= ref_en ? '0 : pre_cnt + PSW'(1);
      tick16    <= div_wrap;
      baud_tick <= div_wrap && (sub_cnt == 4'd15);
      if (ref_en) div_cnt <= div_wrap ? '0 : div_cnt + RW'(1);
      if (div_wrap) sub_cnt <= sub_cnt + 4'd1;
      if (tmr_on && ref_en) begin
        if (tmr_cnt == phase_end) begin
          tmr_cnt   <= '0;
          tmr_pulse <= ~tmr_pulse;
        end else begin
          tmr_cnt <= tmr_cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rate_timer_gen_chk.sv
module rate_timer_gen_chk #(
  parameter int RW      = 8,
  parameter int SYS_DIV = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] rate_in,
  input logic          rate_ld,
  input logic          tick16,
  input logic          baud_tick,
  input logic          tmr_pulse
);
  logic idle_q;
  wire  idle_now = rate_ld ? (rate_in == '0) : idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idle_q <= 1'b1;
    else        idle_q <= idle_now;
  end

  AST_BAUD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> tick16); // R3

  AST_LOAD_CLEARS_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ld |=> (!tick16 && !baud_tick)); // R5

  AST_LOAD_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_ld && rate_in != '0) |=> !tmr_pulse); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle_now |=> $stable(tmr_pulse)); // R6

  generate
    if (SYS_DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |=> !tick16); // R2
    end
  endgenerate
endmodule

bind rate_timer_gen rate_timer_gen_chk #(.RW(RW), .SYS_DIV(SYS_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_in(rate_in), .rate_ld(rate_ld),
  .tick16(tick16), .baud_tick(baud_tick), .tmr_pulse(tmr_pulse));

// File: tb/sim_rate_timer_gen.sv
module sim_rate_timer_gen;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2;

  logic clk = 1'b0, rst_n = 1'b0, rate_ld = 1'b0;
  logic [7:0] rate_in = 8'd0;
  logic tick16, baud_tick, tmr_pulse;

  rate_timer_gen #(.SYS_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_in(rate_in), .rate_ld(rate_ld),
    .tick16(tick16), .baud_tick(baud_tick), .tmr_pulse(tmr_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int q16[$], qbd[$], qtm[$];
  bit qlv[$];
  int win_lo = 0, win_hi = -1;
  int e16, ebd, etm;
  bit elv, prev_p = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > win_lo && cyc <= win_hi) begin
      if (tick16) begin
        if (q16.size() == 0) check(1'b0, "R2", "unexpected 16x tick at", cyc - win_lo, -1);
        else begin
          e16 = q16.pop_front();
          check(cyc == e16, "R2", "16x tick offset", cyc - win_lo, e16 - win_lo);
        end
      end
      if (baud_tick) begin
        if (qbd.size() == 0) check(1'b0, "R3", "unexpected bit tick at", cyc - win_lo, -1);
        else begin
          ebd = qbd.pop_front();
          check(cyc == ebd, "R3", "bit tick offset", cyc - win_lo, ebd - win_lo);
        end
      end
      if (tmr_pulse != prev_p) begin
        if (qtm.size() == 0) check(1'b0, "R4", "unexpected timer edge at", cyc - win_lo, -1);
        else begin
          etm = qtm.pop_front();
          elv = qlv.pop_front();
          check(cyc == etm, "R4", "timer edge offset", cyc - win_lo, etm - win_lo);
          check(tmr_pulse == elv, "R4", "timer level after edge", tmr_pulse, elv);
        end
      end
    end
    prev_p = tmr_pulse;
  end

  task automatic load_rate(input int r, input int rb, input int w,
                           input bit scored, input bit wiggle, input string tag);
    int e0, t;
    @(negedge clk);
    rate_in = 8'(r);
    rate_ld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rate_ld = 1'b0;
    e0 = cyc;
    if (r != 0) check(tmr_pulse == 1'b0, "R4", "timer low at load edge", tmr_pulse, 0);
    if (!scored) return;
    q16.delete(); qbd.delete(); qtm.delete(); qlv.delete();
    for (int k = 1; k * rb * D <= w; k++) q16.push_back(e0 + k * rb * D);
    for (int k = 1; k * 16 * rb * D <= w; k++) qbd.push_back(e0 + k * 16 * rb * D);
    if (r != 0) begin
      t = e0 + 60 * r * D;
      while (t <= e0 + w) begin
        qtm.push_back(t); qlv.push_back(1'b1);
        t += 40 * r * D;
        if (t <= e0 + w) begin qtm.push_back(t); qlv.push_back(1'b0); end
        t += 60 * r * D;
      end
    end
    win_lo = e0;
    win_hi = e0 + w;
    while (cyc < e0 + w + 1) begin
      @(negedge clk);
      if (wiggle) rate_in = 8'(cyc * 37 + 11); // R8: no strobe, no effect
    end
    win_hi = -1;
    check(q16.size() == 0, tag, "16x ticks missing", q16.size(), 0);
    check(qbd.size() == 0, tag, "bit ticks missing", qbd.size(), 0);
    check(qtm.size() == 0, tag, "timer edges missing", qtm.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t1, t2, lv0;
    repeat (4) @(negedge clk);
    check(!tick16 && !baud_tick && !tmr_pulse, "R1", "outputs in reset",
          {tick16, baud_tick, tmr_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tick16 && !baud_tick && !tmr_pulse, "R1", "outputs after reset",
          {tick16, baud_tick, tmr_pulse}, 0);
    while (!tick16) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!tick16) @(negedge clk);
    t2 = cyc;
    check(t2 - t1 == 52 * D, "R1", "default 16x period", t2 - t1, 52 * D);
    repeat (2500) @(negedge clk);
    check(tmr_pulse == 1'b0, "R1", "timer idle after reset", tmr_pulse, 0);

    load_rate(3, 3, 1300, 1'b1, 1'b1, "R8");
    load_rate(1, 1, 500, 1'b1, 1'b0, "R7");
    lv0 = tmr_pulse;
    load_rate(0, 1, 400, 1'b1, 1'b0, "R6");
    check(tmr_pulse == lv0[0], "R6", "timer level held on zero rate", tmr_pulse, lv0);
    load_rate(7, 7, 0, 1'b0, 1'b0, "R5");
    repeat (50) @(negedge clk);
    load_rate(5, 5, 1050, 1'b1, 1'b0, "R5");
    load_rate(255, 255, 31000, 1'b1, 1'b0, "R7");

    summary();
    $finish;
  end
endmodule